// File: doc/BRIEF.md
# Segmented State Access Tree

This block lets a 64-bit software port read and write a large bank of state, 64 segments of 512 bits each (32K bits in all). A request names a segment and one of the eight 64-bit words inside it. The segment is chosen by an address tree: a root, a level of 4 nodes and a level of 16 nodes, each fanning out by four down to the 64 leaves. Only the leaf word of each segment, its first 64 bits, is wired into the tree. The other 448 bits form a serial ring behind the leaf. The ring moves one 64-bit word per cycle.

To reach word k, the controller rotates the chosen segment k times so that word k sits in the leaf. It then reads the leaf, or reads it and overwrites it. After that it rotates the segment the rest of the way round, so the segment is back at word 0. Only one segment is accessed at a time, and only that segment moves. Word 0 costs one busy cycle. Any other word costs a full turn of the ring plus the access cycle.

Requests use a valid/ready handshake. A request is taken in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low until the access is complete. While it is low, the request inputs are ignored, so a source that keeps `req_valid` high simply waits. The response is a single-cycle `rsp_valid` pulse with `rsp_rdata`. The response has no back-pressure: a consumer must take the pulse in the cycle it appears.

Top module: `seg_tree_access`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every word of every segment reads as zero.
- R2: A read of segment s (binary index 0..63 on `req_seg`) and word k (0..7 on `req_word`, word 0 being the leaf word) returns the last value written to that word.
- R3: A write changes only the addressed word. The other seven words of that segment and all words of all other segments keep their values.
- R4: A request is accepted when `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 until the access ends, and request inputs presented while it is 0 have no effect.
- R5: Every access leaves its segment realigned at word 0, so any later access sequence, in any word order, returns correct data.
- R6: `rsp_valid` is a one-cycle pulse in the first cycle `req_ready` is 1 again. `rsp_rdata` carries the word's contents before the access, so a write returns the old value.
- R7: At most one segment rotates in any cycle, none rotates while idle, and segments that are not addressed never move.
- R8: An access to word 0 keeps `req_ready` low for exactly 1 cycle. An access to words 1..7 keeps it low for exactly 9 cycles: k forward rotations, one access cycle and 8−k return rotations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seg | input | 6 | Segment index |
| req_word | input | 3 | Word index within the segment |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Word contents before the access |

## Verification
A segment left mis-rotated after an access does not show up at once. It shows up on the next access to that segment, which returns a neighbouring word, so the bench follows each write with reads in scrambled word orders. A tree decode that enables the wrong leaf, or enables two leaves, corrupts a different segment. That corruption only appears when the victim segment is read back later, so the bench fills bystander segments and re-reads them after heavy traffic elsewhere. A wrong rotation count appears within a single access as a busy time other than 1 or 9 cycles, or as a response pulse out of place.

// File: rtl/sta_pkg.sv
package sta_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FWD,
    ST_ACC,
    ST_BACK
  } sta_state_e;

  // index of the first node of tree level lvl in a flat, root-first node list
  function automatic int lvl_off(input int fanout, input int lvl);
    int acc;
    int width;
    acc   = 0;
    width = 1;
    for (int i = 0; i < lvl; i++) begin
      acc   = acc + width;
      width = width * fanout;
    end
    return acc;
  endfunction

endpackage

// File: rtl/sta_segment.sv
module sta_segment #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] leaf_q
);
  localparam int CHAIN_LEN = WORDS - 1;

  logic [WORD_W-1:0] chain_q [CHAIN_LEN];

  // leaf takes the head of the chain; the old leaf re-enters at the tail
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leaf_q <= '0;
      for (int i = 0; i < CHAIN_LEN; i++) chain_q[i] <= '0;
    end else if (shift_en) begin
      leaf_q <= chain_q[0];
      for (int i = 0; i < CHAIN_LEN - 1; i++) chain_q[i] <= chain_q[i+1];
      chain_q[CHAIN_LEN-1] <= leaf_q;
    end else if (wr_en) begin
      leaf_q <= wr_data;
    end
  end
endmodule

// File: rtl/sta_tree.sv
module sta_tree
  import sta_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int FANOUT = 4,
  parameter int LEVELS = 3
) (
  input  logic [LEVELS*$clog2(FANOUT)-1:0]      seg_idx,
  output logic [FANOUT**LEVELS-1:0]             leaf_sel,
  input  logic [FANOUT**LEVELS-1:0][WORD_W-1:0] leaf_data,
  output logic [WORD_W-1:0]                     root_data
);
  localparam int DIG_W    = $clog2(FANOUT);
  localparam int SEG_CNT  = FANOUT ** LEVELS;
  localparam int NODES    = lvl_off(FANOUT, LEVELS + 1);
  localparam int LEAF_OFF = lvl_off(FANOUT, LEVELS);

  logic [NODES-1:0]             node_en;
  logic [NODES-1:0][WORD_W-1:0] node_dat;

  assign node_en[0] = 1'b1;
  assign root_data  = node_dat[0];

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT_L = FANOUT ** l;
    localparam int OFF   = lvl_off(FANOUT, l);
    localparam int POFF  = lvl_off(FANOUT, l - 1);
    localparam int LSB   = (LEVELS - l) * DIG_W;

    logic [DIG_W-1:0] dig;
    assign dig = seg_idx[LSB +: DIG_W];

    // enable flows down: a node is on when its parent is on and the digit matches
    for (genvar n = 0; n < CNT_L; n++) begin : g_en
      assign node_en[OFF+n] = node_en[POFF + n/FANOUT] && (dig == DIG_W'(n % FANOUT));
    end

    // data flows up: each parent picks one child with the same digit
    for (genvar p = 0; p < CNT_L / FANOUT; p++) begin : g_mux
      logic [FANOUT-1:0][WORD_W-1:0] kids;
      assign kids             = node_dat[OFF + p*FANOUT +: FANOUT];
      assign node_dat[POFF+p] = kids[dig];
    end
  end

  for (genvar s = 0; s < SEG_CNT; s++) begin : g_leaf
    assign leaf_sel[s]           = node_en[LEAF_OFF+s];
    assign node_dat[LEAF_OFF+s]  = leaf_data[s];
  end
endmodule

// File: rtl/sta_ctrl.sv
module sta_ctrl
  import sta_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  parameter int SEG_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [SEG_W-1:0]         req_seg,
  input  logic [$clog2(WORDS)-1:0] req_word,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [WORD_W-1:0]        rsp_rdata,
  output logic [SEG_W-1:0]         acc_seg,
  output logic                     rot_en,
  output logic                     wr_en,
  output logic [WORD_W-1:0]        wr_data,
  input  logic [WORD_W-1:0]        leaf_rd
);
  localparam int               IDX_W    = $clog2(WORDS);
  localparam logic [IDX_W:0]   RING_LEN = (IDX_W + 1)'(WORDS);
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  sta_state_e        state_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  word_q;
  logic              wr_q;
  logic [WORD_W-1:0] rdata_q;
  logic              rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      acc_seg <= '0;
      word_q  <= '0;
      wr_q    <= 1'b0;
      wr_data <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            acc_seg <= req_seg;
            word_q  <= req_word;
            wr_q    <= req_write;
            wr_data <= req_wdata;
            cnt_q   <= req_word;
            state_q <= (req_word == '0) ? ST_ACC : ST_FWD;
          end
        end
        ST_FWD: begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) state_q <= ST_ACC;
        end
        ST_ACC: begin
          rdata_q <= leaf_rd;
          if (word_q == '0) begin
            state_q <= ST_IDLE;
            rsp_q   <= 1'b1;
          end else begin
            cnt_q   <= IDX_W'(RING_LEN - {1'b0, word_q});
            state_q <= ST_BACK;
          end
        end
        ST_BACK: begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) begin
            state_q <= ST_IDLE;
            rsp_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rot_en    = (state_q == ST_FWD) || (state_q == ST_BACK);
  assign wr_en     = (state_q == ST_ACC) && wr_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/seg_tree_access.sv
module seg_tree_access #(
  parameter int WORD_W      = 64,
  parameter int WORDS       = 8,
  parameter int TREE_FANOUT = 4,
  parameter int TREE_LEVELS = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [TREE_LEVELS*$clog2(TREE_FANOUT)-1:0] req_seg,
  input  logic [$clog2(WORDS)-1:0]              req_word,
  input  logic [WORD_W-1:0]                     req_wdata,
  output logic                                  rsp_valid,
  output logic [WORD_W-1:0]                     rsp_rdata
);
  localparam int SEG_W   = TREE_LEVELS * $clog2(TREE_FANOUT);
  localparam int SEG_CNT = TREE_FANOUT ** TREE_LEVELS;
  localparam int IDX_W   = $clog2(WORDS);

  logic [SEG_W-1:0]             acc_seg;
  logic                         rot_en;
  logic                         wr_en;
  logic [WORD_W-1:0]            wr_data;
  logic [WORD_W-1:0]            picked;
  logic [SEG_CNT-1:0]           seg_pick;
  logic [SEG_CNT-1:0]           seg_shift;
  logic [SEG_CNT-1:0]           seg_wr;
  logic [SEG_CNT-1:0][WORD_W-1:0] leaf_words;

  sta_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS), .SEG_W(SEG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_seg   (req_seg),
    .req_word  (req_word),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .acc_seg   (acc_seg),
    .rot_en    (rot_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .leaf_rd   (picked)
  );

  sta_tree #(.WORD_W(WORD_W), .FANOUT(TREE_FANOUT), .LEVELS(TREE_LEVELS)) u_tree (
    .seg_idx   (acc_seg),
    .leaf_sel  (seg_pick),
    .leaf_data (leaf_words),
    .root_data (picked)
  );

  assign seg_shift = seg_pick & {SEG_CNT{rot_en}};
  assign seg_wr    = seg_pick & {SEG_CNT{wr_en}};

  for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
    sta_segment #(.WORD_W(WORD_W), .WORDS(WORDS)) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (seg_shift[s]),
      .wr_en    (seg_wr[s]),
      .wr_data  (wr_data),
      .leaf_q   (leaf_words[s])
    );
  end
endmodule

// File: rtl/sta_checker.sv
module sta_checker #(
  parameter int WORDS   = 8,
  parameter int SEG_CNT = 64,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [IDX_W-1:0]   req_word,
  input logic               rsp_valid,
  input logic [SEG_CNT-1:0] seg_shift
);
  logic [IDX_W-1:0] rot_q;
  logic [IDX_W-1:0] w_q;
  logic [7:0]       busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_q  <= '0;
      w_q    <= '0;
      busy_q <= '0;
    end else begin
      if (req_valid && req_ready) begin
        w_q    <= req_word;
        busy_q <= '0;
      end else if (!req_ready) begin
        busy_q <= busy_q + 8'd1;
      end
      if (|seg_shift) rot_q <= (rot_q == IDX_W'(WORDS - 1)) ? '0 : rot_q + IDX_W'(1);
    end
  end

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  one_seg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_shift));

  // R7
  idle_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (seg_shift == '0));

  // R5
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (rot_q == '0));

  // R6
  rsp_at_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  rsp_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> rsp_valid);

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (int'(busy_q) == ((w_q == '0) ? 1 : WORDS + 1)));
endmodule

bind seg_tree_access sta_checker #(.WORDS(WORDS), .SEG_CNT(SEG_CNT), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_word  (req_word),
  .rsp_valid (rsp_valid),
  .seg_shift (seg_shift)
);

// File: tb/seg_tree_access_bench.sv
`timescale 1ns/1ps
module seg_tree_access_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_seg = '0;
  logic [2:0]  req_word = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_tree_access u_seg_tree_access (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_seg(req_seg), .req_word(req_word),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  seg;
    logic [2:0]  word;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd0,  3'd0, 64'h1111_0000_0000_0000, 64'h0},          // R3 fill
    '{1'b1, 6'd0,  3'd7, 64'h0000_0000_0000_7777, 64'h0},
    '{1'b1, 6'd63, 3'd3, 64'hDEAD_BEEF_0000_0003, 64'h0},
    '{1'b1, 6'd21, 3'd5, 64'h0000_0000_0000_2155, 64'h0},
    '{1'b0, 6'd0,  3'd0, 64'h0, 64'h1111_0000_0000_0000},          // R2
    '{1'b0, 6'd0,  3'd7, 64'h0, 64'h0000_0000_0000_7777},
    '{1'b0, 6'd63, 3'd3, 64'h0, 64'hDEAD_BEEF_0000_0003},
    '{1'b0, 6'd21, 3'd5, 64'h0, 64'h0000_0000_0000_2155},
    '{1'b0, 6'd21, 3'd4, 64'h0, 64'h0},                            // R3 neighbour word
    '{1'b0, 6'd20, 3'd5, 64'h0, 64'h0},                            // R3 neighbour segment
    '{1'b1, 6'd63, 3'd3, 64'h0000_0000_0000_0033, 64'hDEAD_BEEF_0000_0003}, // R6 old value
    '{1'b0, 6'd63, 3'd3, 64'h0, 64'h0000_0000_0000_0033},
    '{1'b0, 6'd63, 3'd2, 64'h0, 64'h0},
    '{1'b0, 6'd0,  3'd1, 64'h0, 64'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; returns response data and number of cycles req_ready was low
  task automatic access(input bit wr, input logic [5:0] seg, input logic [2:0] word,
                        input logic [63:0] data, output logic [63:0] rd, output int busy);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_seg = seg; req_word = word; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    guard = 0;
    while (!req_ready && guard < 100) begin
      busy++;
      guard++;
      @(negedge clk);
    end
    chk(rsp_valid === 1'b1, "R6 pulse", 64'(rsp_valid), 64'd1);
    rd = rsp_rdata;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R6 one cycle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic exp_busy(input logic [2:0] word, input int busy);
    int e;
    e = (word == 3'd0) ? 1 : 9;
    chk(busy == e, "R8 busy length", 64'(busy), 64'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    int busy;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(rsp_valid === 1'b0, "R1 rsp", 64'(rsp_valid), 64'd0);
    access(1'b0, 6'd42, 3'd6, 64'h0, rd, busy);
    chk(rd === 64'h0, "R1 zero word", rd, 64'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].seg, VECS[i].word, VECS[i].data, rd, busy);
      chk(rd === VECS[i].exp, "R2/R3/R6 vector", rd, VECS[i].exp);
      exp_busy(VECS[i].word, busy);
    end

    // R5: fill segment 9 in descending order, read in scrambled order
    for (int w = 7; w >= 0; w--)
      access(1'b1, 6'd9, 3'(w), 64'hA900_0000_0000_0000 | 64'(w), rd, busy);
    for (int j = 0; j < 8; j++) begin
      logic [2:0] w;
      w = 3'((j * 5 + 3) % 8);
      access(1'b0, 6'd9, w, 64'h0, rd, busy);
      chk(rd === (64'hA900_0000_0000_0000 | 64'(w)), "R5 scrambled read", rd,
          64'hA900_0000_0000_0000 | 64'(w));
    end

    // R7: fill segment 1, hammer segment 0 and 2, then re-read segment 1
    for (int w = 0; w < 8; w++)
      access(1'b1, 6'd1, 3'(w), 64'h0101_0000_0000_0000 + 64'(w), rd, busy);
    for (int j = 0; j < 16; j++)
      access(j[0], (j[1] ? 6'd2 : 6'd0), 3'(j % 8), 64'h5A5A_5A5A_0000_0000 + 64'(j), rd, busy);
    for (int w = 0; w < 8; w++) begin
      access(1'b0, 6'd1, 3'(w), 64'h0, rd, busy);
      chk(rd === 64'h0101_0000_0000_0000 + 64'(w), "R7 bystander intact", rd,
          64'h0101_0000_0000_0000 + 64'(w));
    end

    // R4: request inputs while busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_seg = 6'd33; req_word = 3'd4; req_wdata = '0;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b0, "R4 ready low after accept", 64'(req_ready), 64'd0);
    req_write = 1'b1; req_seg = 6'd5; req_word = 3'd1; req_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(rsp_rdata === 64'h0, "R4 first request served", rsp_rdata, 64'h0);
    @(negedge clk);
    access(1'b0, 6'd5, 3'd1, 64'h0, rd, busy);
    chk(rd === 64'h0, "R4 busy-time write ignored", rd, 64'h0);
    access(1'b0, 6'd33, 3'd4, 64'h0, rd, busy);
    chk(rd === 64'h0, "R4 target untouched", rd, 64'h0);

    // R3: all-ones word among zeros at segment boundary 63 word 7
    access(1'b1, 6'd63, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, rd, busy);
    access(1'b0, 6'd63, 3'd6, 64'h0, rd, busy);
    chk(rd === 64'h0, "R3 word 6 unchanged", rd, 64'h0);
    access(1'b0, 6'd63, 3'd0, 64'h0, rd, busy);
    chk(rd === 64'h0, "R3 word 0 unchanged", rd, 64'h0);
    access(1'b0, 6'd63, 3'd7, 64'h0, rd, busy);
    chk(rd === 64'hFFFF_FFFF_FFFF_FFFF, "R2 word 7 readback", rd, 64'hFFFF_FFFF_FFFF_FFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule